// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts

A general-purpose I/O controller for a parameterised number of pins (up to 256). Its state is kept in per-pin bit vectors and presented on a small synchronous register port as 32-bit words. Each word covers one bank of 32 pins. Each register kind has one word per bank. Software configures each pin's enable, direction, driven value, interrupt mask and edge polarity, and reads back the synchronised pin levels and latched interrupt status.

Pin inputs pass through a two-flop synchroniser. A third flop holds the previous sample. Events are found by comparing the current sample with the previous one, or by the level alone in builds without the edge-polarity register. Events latch into a status vector that software clears by writing zeros. Every unmasked status bit feeds one shared, registered interrupt line.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: Byte address = kind*0x20 + bank*4, with bits [1:0] ignored. Kinds: 0 enable, 1 direction, 2 output data, 3 input level (read-only), 4 mask, 5 edge polarity, 6 status, 7 unmapped. Pin p sits in bank p/32 at bit p%32. A read returns the word addressed in the previous cycle, one cycle later. Kind 7, and any bank at or above the bank count, reads as zero.
- R2: `pin_out` equals the output-data register bit for bit.
- R3: `pin_oe` is the enable bit AND NOT the direction bit (direction 1 = input). When the build has no enable register, the enable is taken as 1 and the enable kind reads 0.
- R4: The input-level kind returns each pin's level two clocks after it reaches `pin_in`, whatever the pin's direction.
- R5: With the edge-polarity register present, a polarity bit of 1 latches status on a rising synchronised edge and 0 on a falling one. The status bit is set on the third rising clock after the pin changes.
- R6: Without the edge-polarity register, status is set on every clock on which the synchronised level is high.
- R7: A pin whose enable bit is 0 never sets status.
- R8: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R9: A mask bit of 1 blocks that pin. `irq` is the OR of status AND NOT mask, registered one clock later.
- R10: On reset every register and output is 0, except the mask, which is 1 on every existing pin.
- R11: Bits at or above NUM_PINS in the last bank read as 0 in every kind and never raise status or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Byte address (kind and bank) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Value driven on output pins |
| pin_oe | output | NUM_PINS | Output drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The main instance is built with 40 pins, enable and edge polarity present. The second bank therefore holds only 8 real pins, which exercises the padding bits of a partial last bank alongside full-bank behaviour. A second instance, also with 40 pins, drops both optional registers. This exercises level-high interrupts that re-latch after a clear, and output enables that follow the direction bits alone. A behavioural per-pin model runs beside the main instance and checks read data, pin outputs, enables and the interrupt on every clock.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;
  localparam int BUS_AW    = 8;
  localparam int WORD_W    = 32;
  localparam int BANK_BITS = 3;
  localparam int MAX_PINS  = WORD_W << BANK_BITS;

  typedef enum logic [2:0] {
    K_ENABLE = 3'd0,
    K_DIR    = 3'd1,
    K_OUT    = 3'd2,
    K_LEVEL  = 3'd3,
    K_MASK   = 3'd4,
    K_EDGE   = 3'd5,
    K_STATUS = 3'd6,
    K_NONE   = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic                 wr;
    reg_kind_e            kind;
    logic [BANK_BITS-1:0] bank;
    logic [WORD_W-1:0]    data;
  } bus_cmd_t;

  function automatic reg_kind_e addr_kind(input logic [BUS_AW-1:0] a);
    return reg_kind_e'(a[7:5]);
  endfunction

  function automatic logic [BANK_BITS-1:0] addr_bank(input logic [BUS_AW-1:0] a);
    return a[4:2];
  endfunction

  // true when command c writes register kind k in the bank holding pin p
  function automatic logic cmd_hits(input bus_cmd_t c, input reg_kind_e k, input int p);
    return c.wr && (c.kind == k) && (int'(c.bank) == p / WORD_W);
  endfunction
endpackage

// File: rtl/bgpio_sense.sv
module bgpio_sense
  import bgpio_pkg::*;
#(
  parameter int NUM_PINS     = 40,
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] edge_sel,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] event_o
);
  logic [NUM_PINS-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign level = cur_q;

  generate
    if (HAS_EDGE_SEL) begin : g_edge
      logic [NUM_PINS-1:0] rise, fall;
      assign rise    = cur_q & ~prev_q;
      assign fall    = ~cur_q & prev_q;
      assign event_o = en & ((edge_sel & rise) | (~edge_sel & fall));
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = ^{edge_sel, prev_q};
      assign event_o    = en & cur_q;
      // R6: in level mode an event needs the synchroniser output high one clock after the pin was seen
      p_level_src_r6: assert property (@(posedge clk) disable iff (rst)
        ((event_o & ~$past(meta_q)) == '0));
    end
  endgenerate
endmodule

// File: rtl/bgpio_intr.sv
module bgpio_intr
  import bgpio_pkg::*;
#(
  parameter int NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  bus_cmd_t            cmd,
  input  logic [NUM_PINS-1:0] ev,
  input  logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] st_q,
  output logic                irq_q
);
  logic [NUM_PINS-1:0] keep, st_d;
  logic                clr_wr;

  assign clr_wr = cmd.wr && (cmd.kind == K_STATUS);

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      keep[p] = !cmd_hits(cmd, K_STATUS, p) || cmd.data[p % WORD_W];
      st_d[p] = (st_q[p] & keep[p]) | ev[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= |(st_q & ~mask);
    end
  end

  // R5: a status bit only rises after the detector reported an event for it
  p_set_needs_event_r5: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~$past(st_q) & ~$past(ev)) == '0));
  // R8: without a status write no bit can fall
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> (($past(st_q) & ~st_q) == '0));
  // R9: the interrupt follows an unmasked status bit of the cycle before
  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(st_q & ~mask)));
endmodule

// File: rtl/bgpio_cfg.sv
module bgpio_cfg
  import bgpio_pkg::*;
#(
  parameter int NUM_PINS     = 40,
  parameter bit HAS_ENABLE   = 1'b1,
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bus_cmd_t             cmd,
  input  reg_kind_e            rd_kind,
  input  logic [BANK_BITS-1:0] rd_bank,
  input  logic [NUM_PINS-1:0]  level,
  input  logic [NUM_PINS-1:0]  status,
  output logic [NUM_PINS-1:0]  en_q,
  output logic [NUM_PINS-1:0]  dir_q,
  output logic [NUM_PINS-1:0]  out_q,
  output logic [NUM_PINS-1:0]  mask_q,
  output logic [NUM_PINS-1:0]  edge_q,
  output logic [NUM_PINS-1:0]  oe,
  output logic [WORD_W-1:0]    rdata_q
);
  localparam int NBANK = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PADW  = NBANK * WORD_W;
  localparam int LASTV = NUM_PINS - (NBANK - 1) * WORD_W;

  logic [NUM_PINS-1:0] en_vis, edge_vis;
  logic [PADW-1:0]     src;
  logic [WORD_W-1:0]   word;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '1;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (cmd_hits(cmd, K_DIR, p))  dir_q[p]  <= cmd.data[p % WORD_W];
        if (cmd_hits(cmd, K_OUT, p))  out_q[p]  <= cmd.data[p % WORD_W];
        if (cmd_hits(cmd, K_MASK, p)) mask_q[p] <= cmd.data[p % WORD_W];
      end
    end
  end

  generate
    if (HAS_ENABLE) begin : g_en
      always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else
          for (int p = 0; p < NUM_PINS; p++)
            if (cmd_hits(cmd, K_ENABLE, p)) en_q[p] <= cmd.data[p % WORD_W];
      end
      assign en_vis = en_q;
    end else begin : g_no_en
      assign en_q   = '1;
      assign en_vis = '0;
    end

    if (HAS_EDGE_SEL) begin : g_pol
      always_ff @(posedge clk) begin
        if (rst) edge_q <= '0;
        else
          for (int p = 0; p < NUM_PINS; p++)
            if (cmd_hits(cmd, K_EDGE, p)) edge_q[p] <= cmd.data[p % WORD_W];
      end
      assign edge_vis = edge_q;
    end else begin : g_no_pol
      assign edge_q   = '0;
      assign edge_vis = '0;
    end
  endgenerate

  assign oe = en_q & ~dir_q;

  always_comb begin
    src = '0;
    unique case (rd_kind)
      K_ENABLE: src[NUM_PINS-1:0] = en_vis;
      K_DIR:    src[NUM_PINS-1:0] = dir_q;
      K_OUT:    src[NUM_PINS-1:0] = out_q;
      K_LEVEL:  src[NUM_PINS-1:0] = level;
      K_MASK:   src[NUM_PINS-1:0] = mask_q;
      K_EDGE:   src[NUM_PINS-1:0] = edge_vis;
      K_STATUS: src[NUM_PINS-1:0] = status;
      default:  src = '0;
    endcase
    word = '0;
    for (int b = 0; b < NBANK; b++)
      if (int'(rd_bank) == b) word = src[b*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= word;
  end

  // R3: the drive enables move only in the cycle after a register write
  p_oe_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe) |-> $past(cmd.wr));

  generate
    if (LASTV < WORD_W) begin : g_pad_chk
      // R11: padding bits of the last bank always read back as zero
      p_pad_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_bank) == NBANK - 1) |=> (rdata_q[WORD_W-1:LASTV] == '0));
    end
  endgenerate
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import bgpio_pkg::*;
#(
  parameter int NUM_PINS     = 40,
  parameter bit HAS_ENABLE   = 1'b1,
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  bus_cmd_t            cmd;
  logic [NUM_PINS-1:0] en_q, dir_q, mask_q, edge_q, level, ev, st_q;
  logic [1:0]          unused_lsb;

  assign unused_lsb = bus_addr[1:0];
  assign cmd.wr     = bus_wr;
  assign cmd.kind   = addr_kind(bus_addr);
  assign cmd.bank   = addr_bank(bus_addr);
  assign cmd.data   = bus_wdata;

  bgpio_cfg #(
    .NUM_PINS(NUM_PINS), .HAS_ENABLE(HAS_ENABLE), .HAS_EDGE_SEL(HAS_EDGE_SEL)
  ) u_cfg (
    .clk(clk), .rst(rst), .cmd(cmd),
    .rd_kind(cmd.kind), .rd_bank(cmd.bank),
    .level(level), .status(st_q),
    .en_q(en_q), .dir_q(dir_q), .out_q(pin_out), .mask_q(mask_q),
    .edge_q(edge_q), .oe(pin_oe), .rdata_q(bus_rdata)
  );

  bgpio_sense #(
    .NUM_PINS(NUM_PINS), .HAS_EDGE_SEL(HAS_EDGE_SEL)
  ) u_sense (
    .clk(clk), .rst(rst), .pin_in(pin_in), .en(en_q), .edge_sel(edge_q),
    .level(level), .event_o(ev)
  );

  bgpio_intr #(
    .NUM_PINS(NUM_PINS)
  ) u_intr (
    .clk(clk), .rst(rst), .cmd(cmd), .ev(ev), .mask(mask_q),
    .st_q(st_q), .irq_q(irq)
  );

  initial begin
    p_pin_count_r1: assert (NUM_PINS >= 1 && NUM_PINS <= MAX_PINS)
      else $error("NUM_PINS out of range");
  end

  logic unused_dir;
  assign unused_dir = ^dir_q;
endmodule

// File: tb/sim_banked_gpio_ctrl.sv
module sim_banked_gpio_ctrl;
  localparam int NP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pin = '0, pout, poe;
  logic        irq;

  logic        b_wr = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic [NP-1:0] b_pin = '0, b_pout, b_poe;
  logic        b_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_gpio_ctrl #(.NUM_PINS(NP), .HAS_ENABLE(1'b1), .HAS_EDGE_SEL(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin), .pin_out(pout), .pin_oe(poe), .irq(irq));

  banked_gpio_ctrl #(.NUM_PINS(NP), .HAS_ENABLE(1'b0), .HAS_EDGE_SEL(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(b_rdata), .pin_in(b_pin), .pin_out(b_pout), .pin_oe(b_poe), .irq(b_irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ad(input int kind, input int bank);
    return 8'((kind << 5) | (bank << 2));
  endfunction

  // ---- behavioural reference of u0, one step per clock ----
  bit m_en[NP], m_dir[NP], m_out[NP], m_mask[NP], m_pol[NP], m_st[NP];
  bit m_s1[NP], m_s2[NP], m_s3[NP];
  bit m_irq;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_en[p]) begin
        m_en[p] = 0; m_dir[p] = 0; m_out[p] = 0; m_mask[p] = 1; m_pol[p] = 0;
        m_st[p] = 0; m_s1[p] = 0; m_s2[p] = 0; m_s3[p] = 0;
      end
      m_irq = 0; m_rdata = '0;
    end else begin
      int kind, bank;
      bit ev[NP];
      bit any;
      kind = int'(addr[7:5]); bank = int'(addr[4:2]);
      m_rdata = '0;
      any = 0;
      foreach (m_en[p]) begin
        bit v;
        case (kind)
          0: v = m_en[p];   1: v = m_dir[p]; 2: v = m_out[p]; 3: v = m_s2[p];
          4: v = m_mask[p]; 5: v = m_pol[p]; 6: v = m_st[p];  default: v = 0;
        endcase
        if (p / 32 == bank) m_rdata[p % 32] = v;
        ev[p] = m_en[p] && (m_pol[p] ? (m_s2[p] && !m_s3[p]) : (!m_s2[p] && m_s3[p]));
        if (m_st[p] && !m_mask[p]) any = 1;
      end
      m_irq = any;
      foreach (m_en[p]) begin
        if (wr && p / 32 == bank) begin
          bit d;
          d = wdata[p % 32];
          case (kind)
            0: m_en[p] = d;   1: m_dir[p] = d; 2: m_out[p] = d;
            4: m_mask[p] = d; 5: m_pol[p] = d; 6: if (!d) m_st[p] = 0;
            default: ;
          endcase
        end
        if (ev[p]) m_st[p] = 1;
        m_s3[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = pin[p];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NP-1:0] e_out, e_oe;
      foreach (m_en[p]) begin
        e_out[p] = m_out[p];
        e_oe[p]  = m_en[p] && !m_dir[p];
      end
      chk("R1 model read data", 64'(rdata), 64'(m_rdata));
      chk("R2 model pin_out", 64'(pout), 64'(e_out));
      chk("R3 model pin_oe", 64'(poe), 64'(e_oe));
      chk("R9 model irq", 64'(irq), 64'(m_irq));
    end
  end

  task automatic w0(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic r0(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask
  task automatic w1(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk); b_wr = 1'b0;
  endtask
  task automatic r1(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); b_addr = a;
    @(negedge clk); d = b_rdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    r0(ad(4, 0), d); chk("R10 mask bank0 after reset", 64'(d), 64'hFFFF_FFFF);
    r0(ad(4, 1), d); chk("R10/R11 mask bank1 after reset", 64'(d), 64'h0000_00FF);
    r0(ad(0, 0), d); chk("R10 enable after reset", 64'(d), 64'h0);
    chk("R10 pin_oe after reset", 64'(poe), 64'h0);

    // R2 / R3 output path
    w0(ad(0, 0), 32'h0000_00FF);
    w0(ad(1, 0), 32'h0000_000F);
    w0(ad(2, 0), 32'h0000_00A5);
    idle(1);
    chk("R2 pin_out low byte", 64'(pout[7:0]), 64'hA5);
    chk("R3 pin_oe low byte", 64'(poe[7:0]), 64'hF0);

    // R4 input level regardless of direction (pin1 input, pin5 output)
    pin[1] = 1'b1; pin[5] = 1'b1;
    idle(3);
    r0(ad(3, 0), d); chk("R4 level read", 64'(d), 64'h22);
    r0(ad(6, 0), d); chk("R5 no status on rise in falling mode", 64'(d), 64'h0);

    // R5 rising on pin0, falling on pin1; R7 disabled pin20 toggles
    w0(ad(5, 0), 32'h1);
    pin[0] = 1'b1; idle(4);
    pin[1] = 1'b0; pin[20] = 1'b1; idle(4);
    pin[20] = 1'b0; idle(4);
    r0(ad(6, 0), d); chk("R5/R7 status after edges", 64'(d), 64'h3);

    // R9 mask
    chk("R9 irq while masked", 64'(irq), 64'h0);
    w0(ad(4, 0), 32'hFFFF_FFFE);
    idle(1);
    chk("R9 irq after unmask", 64'(irq), 64'h1);

    // R8 write-one keeps, write-zero clears
    w0(ad(6, 0), 32'hFFFF_FFFF);
    r0(ad(6, 0), d); chk("R8 write ones no effect", 64'(d), 64'h3);
    w0(ad(6, 0), 32'hFFFF_FFFE);
    r0(ad(6, 0), d); chk("R8 clear bit0", 64'(d), 64'h2);
    idle(1);
    chk("R9 irq low after clear", 64'(irq), 64'h0);

    // R8 event coinciding with clear survives
    pin[0] = 1'b0; idle(4);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    w0(ad(6, 0), 32'hFFFF_FFFE);
    r0(ad(6, 0), d); chk("R8 event wins over clear", 64'(d), 64'h3);

    // R11 partial last bank, R1 unmapped space
    w0(ad(0, 1), 32'hFFFF_FFFF);
    r0(ad(0, 1), d); chk("R11 enable bank1 padding", 64'(d), 64'hFF);
    w0(ad(5, 1), 32'hFFFF_FFFF);
    pin[39:32] = 8'hFF; idle(4);
    r0(ad(6, 1), d); chk("R11 status bank1", 64'(d), 64'hFF);
    r0(ad(7, 0), d); chk("R1 unmapped kind", 64'(d), 64'h0);
    r0(ad(0, 5), d); chk("R1 bank beyond count", 64'(d), 64'h0);

    // level-mode instance without enable register
    chk("R3 no-enable oe follows direction", 64'(b_poe), 64'(40'hFF_FFFF_FFFF));
    w1(ad(1, 0), 32'hFFFF_FFFF);
    idle(1);
    chk("R3 no-enable oe after dir write", 64'(b_poe), 64'(40'hFF_0000_0000));
    r1(ad(0, 0), d); chk("R3 absent enable reads zero", 64'(d), 64'h0);
    w1(ad(4, 0), 32'hFFFF_FFF7);
    b_pin[3] = 1'b1; idle(4);
    chk("R6 level irq", 64'(b_irq), 64'h1);
    w1(ad(6, 0), 32'h0);
    r1(ad(6, 0), d); chk("R6 level re-latches after clear", 64'(d), 64'h8);
    b_pin[3] = 1'b0; idle(4);
    w1(ad(6, 0), 32'h0);
    r1(ad(6, 0), d); chk("R6 status stays clear when low", 64'(d), 64'h0);
    idle(1);
    chk("R9 level irq drops", 64'(b_irq), 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule